// File: doc/BRIEF.md
# E1 Basic Frame Alignment Search and Monitor

This block takes a received 2.048 Mb/s E1 bit stream, one bit at a time under a bit-clock enable, and finds where the frames start. It looks for the 7-bit alignment word that appears in time slot 0 of every second frame. It accepts a candidate only after three frames behave as expected: the word is present, then absent, then present again. Once it accepts a position, it reports that it is in sync. It also provides a frame-start strobe, the bit position within the 256-bit frame, and a flag that shows whether the current frame is an alignment-word frame or an alternate frame.

While in sync, the block checks time slot 0 of every frame. A run of three bad alignment words drops sync and restarts the search. A mode input adds a second loss rule: three alternate frames in a row with bit 2 of time slot 0 at 0 also drop sync. The first rule still applies when this mode is on. Multiframe alignment, CRC checking and line decoding belong to neighbouring blocks.

Top module: `e1_frame_align`

## Requirements
- R1: After reset, in_sync is 0, frame_start is 0, bit_pos is 0 and fas_frame is 0.
- R2: Bits arrive with bit 1 of a time slot first. Frame positions 1..7 (bits 2..8 of time slot 0) carry the alignment word 0011011, leftmost bit first. While hunting, a match on any enabled bit marks that bit as position 7 of an alignment-word frame. bit_pos then continues from 8 and fas_frame is 1.
- R3: Sync is declared at position 7 of frame N+2. This needs the word in frame N, no word at positions 1..7 of frame N+1, and the word in frame N+2. in_sync rises on the clock edge that takes that bit.
- R4: If frame N+1 holds the word, the candidate is dropped. The search resumes with the following bit.
- R5: If frame N+2 lacks the word, the candidate is dropped. The search resumes with the following bit.
- R6: In sync, three alignment-word frames in a row with a wrong word drop in_sync. It falls on the edge that takes position 7 of the third one.
- R7: A correct alignment word clears the run of bad alignment words.
- R8: With alt_mode at 0, a 0 at bit 2 of time slot 0 (position 1) in alternate frames has no effect on in_sync.
- R9: With alt_mode at 1, three alternate frames in a row with position 1 at 0 drop in_sync at position 7 of the third. An alternate frame with position 1 at 1 clears that run.
- R10: With alt_mode at 1, the three-bad-word rule of R6 still drops sync.
- R11: bit_pos counts 0..255 and wraps to 0, and fas_frame toggles at each wrap. In sync, frame_start is 1 exactly while bit_pos is 0, which lasts one enabled bit time.
- R12: While bit_en is 0, rx_bit is ignored and bit_pos, fas_frame, in_sync and frame_start hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies rx_bit for one clock |
| rx_bit | input | 1 | Received serial data bit |
| alt_mode | input | 1 | 1 adds the bit-2 loss rule |
| in_sync | output | 1 | Frame alignment held |
| frame_start | output | 1 | Next bit is frame position 0 (in sync only) |
| bit_pos | output | 8 | Frame position of the next enabled bit |
| fas_frame | output | 1 | 1 while the current frame is an alignment-word frame |

## Verification
Every result is registered, so it changes on the same clock edge that takes the deciding bit. Acceptance and loss show on the edge that takes position 7. The strobe and position change on the edge of each enabled bit. The bench gives each bit one enabled clock followed by one idle clock, and it samples on the falling edge after that. A check made after position 6 must therefore still show the old state, and the check after position 7 must show the new one. Both checks are made at each transition point to pin the exact cycle.

// File: rtl/e1a_pkg.sv
package e1a_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_VER1 = 2'd1,
      ST_VER2 = 2'd2,
      ST_LOCK = 2'd3
   } align_state_t;

   localparam logic [6:0] E1A_WORD_DEFAULT = 7'b0011011;
endpackage

// File: rtl/e1a_bit_window.sv
module e1a_bit_window #(
   parameter int WIN_BITS = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_en,
   input  logic                rx_bit,
   output logic [WIN_BITS-1:0] win_next
);
   localparam int HIST_W = WIN_BITS - 1;

   logic [HIST_W-1:0] hist_q;

   initial begin
      assert (WIN_BITS >= 2) else $error("window must hold at least two bits");
   end

   assign win_next = {hist_q, rx_bit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '1;
      end else if (bit_en) begin
         hist_q <= win_next[HIST_W-1:0];
      end
   end

   // R12
   win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(hist_q));
endmodule

// File: rtl/e1a_frame_timer.sv
module e1a_frame_timer #(
   parameter int FRAME_BITS = 256,
   parameter int LOAD_POS   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bit_en,
   input  logic                          load,
   output logic [$clog2(FRAME_BITS)-1:0] pos,
   output logic                          fas_frame
);
   localparam int POS_W = $clog2(FRAME_BITS);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
   localparam logic [POS_W-1:0] LOAD_VAL = POS_W'(LOAD_POS);

   initial begin
      assert (LOAD_POS > 0 && LOAD_POS < FRAME_BITS) else $error("load position out of frame");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos       <= '0;
         fas_frame <= 1'b0;
      end else if (bit_en) begin
         if (load) begin
            pos       <= LOAD_VAL;
            fas_frame <= 1'b1;
         end else if (pos == LAST_POS) begin
            pos       <= '0;
            fas_frame <= ~fas_frame;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

   // R12
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(pos) && $stable(fas_frame));

   // R11
   timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !load && pos == LAST_POS |=> pos == '0 && fas_frame != $past(fas_frame));
endmodule

// File: rtl/e1a_err_run.sv
module e1a_err_run #(
   parameter int RUN_LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ok_ev,
   input  logic bad_ev,
   output logic run_done
);
   localparam int CNT_W = $clog2(RUN_LIMIT + 1);
   localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(RUN_LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (RUN_LIMIT >= 2) else $error("run limit must be at least two");
   end

   assign run_done = bad_ev && !clr && (cnt_q == TOP_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || ok_ev || run_done) begin
         cnt_q <= '0;
      end else if (bad_ev) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6
   run_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOP_VAL);

   // R7
   run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_ev |=> cnt_q == '0);
endmodule

// File: rtl/e1_frame_align.sv
module e1_frame_align
   import e1a_pkg::*;
#(
   parameter int               FRAME_BITS  = 256,
   parameter int               SLOT_BITS   = 8,
   parameter logic [6:0]       ALIGN_WORD  = E1A_WORD_DEFAULT,
   parameter int               LOSS_RUN    = 3,
   parameter bit               ALT_RULE_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bit_en,
   input  logic                          rx_bit,
   input  logic                          alt_mode,
   output logic                          in_sync,
   output logic                          frame_start,
   output logic [$clog2(FRAME_BITS)-1:0] bit_pos,
   output logic                          fas_frame
);
   localparam int POS_W     = $clog2(FRAME_BITS);
   localparam int WORD_W    = SLOT_BITS - 1;
   localparam int CHECK_POS = SLOT_BITS - 1;
   localparam int LOAD_POS  = SLOT_BITS;

   initial begin
      assert (SLOT_BITS == 8) else $error("alignment word is sized for 8-bit slots");
      assert (FRAME_BITS >= 2 * SLOT_BITS) else $error("frame shorter than two slots");
      assert (LOSS_RUN >= 2) else $error("loss run must be at least two");
   end

   logic [WORD_W-1:0] win_next;
   logic [POS_W-1:0]  pos_q;
   logic              fas_q;
   align_state_t      st_q, st_d;
   logic              chk, word_seen, b2_ok, load, locked;
   logic              word_done, b2_done;

   e1a_bit_window #(.WIN_BITS(WORD_W)) win_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .win_next(win_next)
   );

   e1a_frame_timer #(.FRAME_BITS(FRAME_BITS), .LOAD_POS(LOAD_POS)) tmr_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load),
      .pos(pos_q), .fas_frame(fas_q)
   );

   assign chk       = bit_en && (pos_q == POS_W'(CHECK_POS));
   assign word_seen = (win_next == ALIGN_WORD[WORD_W-1:0]);
   assign b2_ok     = win_next[WORD_W-1];
   assign locked    = (st_q == ST_LOCK);
   assign load      = (st_q == ST_HUNT) && bit_en && word_seen;

   e1a_err_run #(.RUN_LIMIT(LOSS_RUN)) word_run_i (
      .clk(clk), .rst_n(rst_n),
      .clr(!locked),
      .ok_ev(locked && chk && fas_q && word_seen),
      .bad_ev(locked && chk && fas_q && !word_seen),
      .run_done(word_done)
   );

   generate
      if (ALT_RULE_EN) begin : g_alt
         e1a_err_run #(.RUN_LIMIT(LOSS_RUN)) b2_run_i (
            .clk(clk), .rst_n(rst_n),
            .clr(!locked || !alt_mode),
            .ok_ev(locked && chk && !fas_q && b2_ok),
            .bad_ev(locked && chk && !fas_q && !b2_ok),
            .run_done(b2_done)
         );
      end else begin : g_noalt
         assign b2_done = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_HUNT: if (load) st_d = ST_VER1;
         ST_VER1: if (chk) st_d = word_seen ? ST_HUNT : ST_VER2;
         ST_VER2: if (chk) st_d = word_seen ? ST_LOCK : ST_HUNT;
         ST_LOCK: if (word_done || b2_done) st_d = ST_HUNT;
         default: st_d = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_HUNT;
      else        st_q <= st_d;
   end

   assign in_sync     = locked;
   assign frame_start = locked && (pos_q == '0);
   assign bit_pos     = pos_q;
   assign fas_frame   = fas_q;

   // R3
   sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> $past(bit_en) && $past(pos_q) == POS_W'(CHECK_POS) && fas_q);

   // R6
   loss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sync) |-> $past(word_done || b2_done));

   // R8
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_sync && !alt_mode && !word_done |=> in_sync);

   // R2
   hunt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> bit_pos == POS_W'(LOAD_POS) && fas_frame && st_q == ST_VER1);

   // R11
   strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start && bit_en |=> !frame_start);
endmodule

// File: tb/e1_frame_align_tb_top.sv
module e1_frame_align_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       rx_bit = 1'b1;
   logic       alt_mode = 1'b0;
   logic       in_sync, frame_start, fas_frame;
   logic [7:0] bit_pos;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [6:0] WORD = 7'b0011011;

   always #5 clk = ~clk;

   e1_frame_align dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .alt_mode(alt_mode), .in_sync(in_sync), .frame_start(frame_start),
      .bit_pos(bit_pos), .fas_frame(fas_frame)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic frame_bit(input bit is_word, input bit good, input int p);
      if (p >= 1 && p <= 7) begin
         if (is_word) return good ? WORD[7-p] : 1'b1;
         else         return (p == 1) ? good : 1'b1;
      end
      return 1'b1;
   endfunction

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_en = 1'b1;
      rx_bit = b;
      @(negedge clk);
      bit_en = 1'b0;
      rx_bit = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_span(input bit is_word, input bit good, input int first, input int last);
      for (int p = first; p <= last; p++) send_bit(frame_bit(is_word, good, p));
   endtask

   task automatic send_frame(input bit is_word, input bit good);
      send_span(is_word, good, 0, 255);
   endtask

   task automatic restart(input bit alt);
      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b1; alt_mode = alt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 37; i++) send_bit(1'b1);
   endtask

   task automatic acquire(input bit alt);
      restart(alt);
      send_frame(1, 1);
      send_frame(0, 1);
      send_span(1, 1, 0, 6);
      check("R3 before third word", in_sync, 0);
      send_span(1, 1, 7, 7);
      check("R3 sync at position 7", in_sync, 1);
      check("R2 bit_pos after word", bit_pos, 8);
      check("R2 fas_frame after word", fas_frame, 1);
      send_span(1, 1, 8, 255);
      check("R11 frame_start at wrap", frame_start, 1);
      check("R11 bit_pos wrap", bit_pos, 0);
      check("R11 fas_frame toggle", fas_frame, 0);
      send_span(0, 1, 0, 0);
      check("R11 strobe one bit", frame_start, 0);
      check("R11 bit_pos advance", bit_pos, 1);
      send_span(0, 1, 1, 255);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in_sync", in_sync, 0);
      check("R1 frame_start", frame_start, 0);
      check("R1 bit_pos", bit_pos, 0);
      check("R1 fas_frame", fas_frame, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_verify_n1_fail();
      restart(0);
      send_frame(1, 1);
      send_frame(1, 1);
      send_span(1, 1, 0, 7);
      check("R4 word in N+1 rejects", in_sync, 0);
      send_span(1, 1, 8, 255);
      send_frame(0, 1);
      send_span(1, 1, 0, 6);
      check("R4 resumed search pending", in_sync, 0);
      send_span(1, 1, 7, 7);
      check("R4 resumed search locks", in_sync, 1);
   endtask

   task automatic t_verify_n2_fail();
      restart(0);
      send_frame(1, 1);
      send_frame(0, 1);
      send_frame(0, 1);
      check("R5 missing word in N+2", in_sync, 0);
      send_frame(1, 1);
      send_frame(0, 1);
      send_span(1, 1, 0, 6);
      check("R5 retry pending", in_sync, 0);
      send_span(1, 1, 7, 7);
      check("R5 retry locks", in_sync, 1);
   endtask

   task automatic bad_word_loss(input bit alt, input string tag);
      acquire(alt);
      send_frame(1, 0);
      send_frame(0, 1);
      send_frame(1, 0);
      send_frame(0, 1);
      send_span(1, 0, 0, 6);
      check({tag, " held before third bad word"}, in_sync, 1);
      send_span(1, 0, 7, 7);
      check({tag, " lost at third bad word"}, in_sync, 0);
   endtask

   task automatic t_runs_clear();
      acquire(1);
      send_frame(1, 0); send_frame(0, 0);
      send_frame(1, 0); send_frame(0, 0);
      send_frame(1, 1); send_frame(0, 1);
      send_frame(1, 0); send_frame(0, 0);
      send_frame(1, 0); send_frame(0, 0);
      check("R7 word run cleared", in_sync, 1);
      check("R9 bit-2 run cleared", frame_start, 1);
   endtask

   task automatic t_b2_ignored();
      acquire(0);
      for (int i = 0; i < 4; i++) begin
         send_frame(1, 1);
         send_frame(0, 0);
      end
      check("R8 bit-2 errors ignored", in_sync, 1);
   endtask

   task automatic t_b2_loss();
      acquire(1);
      send_frame(1, 1); send_frame(0, 0);
      send_frame(1, 1); send_frame(0, 0);
      send_frame(1, 1);
      send_span(0, 0, 0, 6);
      check("R9 held before third bad bit 2", in_sync, 1);
      send_span(0, 0, 7, 7);
      check("R9 lost at third bad bit 2", in_sync, 0);
   endtask

   task automatic t_hold();
      logic [7:0] bp;
      acquire(0);
      bp = bit_pos;
      @(negedge clk);
      bit_en = 1'b0;
      rx_bit = 1'b0;
      repeat (6) @(negedge clk);
      check("R12 bit_pos held", bit_pos, bp);
      check("R12 strobe held", frame_start, 1);
      check("R12 fas_frame held", fas_frame, 1);
      rx_bit = 1'b1;
      send_frame(1, 1);
      check("R12 sync kept", in_sync, 1);
      check("R11 fas_frame after wrap", fas_frame, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      acquire(0);
      t_verify_n1_fail();
      t_verify_n2_fail();
      bad_word_loss(0, "R6");
      bad_word_loss(1, "R10");
      t_runs_clear();
      t_b2_ignored();
      t_b2_loss();
      t_hold();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule